// File: doc/BRIEF.md
# Priority interrupt arbiter with re-arm

This block picks one winning interrupt line out of one to three banks of 32 lines each. For every line it receives a pending bit, a mask bit, a fast-route bit and a priority value. It serves two independent channels: a normal channel and a fast channel. The fast-route bit of each line decides which channel can see that line.

Each channel holds an arm flag. A channel raises its request output at most once per arming. When it raises the request, it records the global number of the winning line and clears its arm flag. The output then stays high until software re-arms that channel. A global enable input holds both channels back while it is low.

The winner search is a single combinational pass over all lines. Its result is registered only at the moment a request is raised. The register bus, the input edge detection and the configuration storage live outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: Line k is a candidate for the fast channel when `pend_i[k]`=1, `mask_i[k]`=0 and `fast_i[k]`=1. It is a candidate for the normal channel under the same pending and mask conditions with `fast_i[k]`=0. A masked or wrongly routed line never wins.
- R2: Among candidates, the numerically lowest priority value wins. Value 0 is the most urgent. The priority of line k sits in `prio_i[k*PRIO_W +: PRIO_W]`.
- R3: When several candidates share the best priority, the one with the highest global line number wins. This applies within a bank and across banks.
- R4: The reported code is the global line number, 32 × bank + bit index. It equals the bit position k in `pend_i`. Normal codes appear on `norm_code_o` and fast codes on `fast_code_o`.
- R5: A channel's request bit rises on the clock edge after its arm flag, at least one candidate and `glb_en_i` are present together. On that edge the arm flag clears and the code is latched. The request then stays high, and later input changes do not alter the code.
- R6: `rearm_i[0]` (normal) or `rearm_i[1]` (fast) behaves as follows on the next edge: the channel's request goes low and its arm flag is set. On the edge after that, the channel evaluates again. While re-arm is held high, the request stays low.
- R7: After reset both arm flags are set, both requests (`req_o[0]` normal, `req_o[1]` fast) are low and both codes are 0.
- R8: A code register changes only on the edge where its request rises. A re-arm, or an evaluation with no candidate, leaves the previous code in place.
- R9: While `glb_en_i` is low, no request rises and arm flags are kept. When the enable goes high with a candidate present, the request rises on the next edge.
- R10: A re-arm of one channel does not change the other channel's request or code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global enable for both channels |
| pend_i | input | 32*N_BANKS | Pending bit per global line |
| mask_i | input | 32*N_BANKS | Mask bit per line, 1 = masked |
| fast_i | input | 32*N_BANKS | Route bit per line, 1 = fast channel |
| prio_i | input | 32*N_BANKS*PRIO_W | Priority value per line, packed by line number |
| rearm_i | input | 2 | Re-arm request, bit 0 normal, bit 1 fast |
| req_o | output | 2 | Channel request, bit 0 normal, bit 1 fast |
| norm_code_o | output | CODE_W | Latched winning line of the normal channel |
| fast_code_o | output | CODE_W | Latched winning line of the fast channel |

## Verification
The main function is tried with patterns that isolate a single rule each. A lone pending line checks the code mapping. Three lines with distinct priorities in different banks separate lowest-value selection from position. Equal-priority sets inside bank 0 and across banks show the high-index tie rule. Mixed fast and normal lines, together with masked lines of the best priority, confirm that routing and masking shape the candidate set. Directed sequences then add lines after an assertion and re-arm one channel while the other is held. They also pulse and hold the enable and re-arm inputs, which separates once-per-arming behaviour, code retention and one-cycle re-evaluation from a design that simply tracks the current winner.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned NUM_CHANNELS   = 2;
    localparam int unsigned CH_NORMAL      = 0;
    localparam int unsigned CH_FAST        = 1;

    function automatic int unsigned code_width(input int unsigned lines);
        return (lines <= 2) ? 1 : $clog2(lines);
    endfunction
endpackage

// File: rtl/irq_arb_search.sv
module irq_arb_search #(
    parameter int unsigned LINES    = 96,
    parameter int unsigned PRIO_W   = 6,
    parameter int unsigned CODE_W   = 7,
    parameter bit          FAST_SEL = 1'b0
) (
    input  logic [LINES-1:0]        pend_i,
    input  logic [LINES-1:0]        mask_i,
    input  logic [LINES-1:0]        fast_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    output logic                    any_o,
    output logic [CODE_W-1:0]       win_o
);
    logic [LINES-1:0] cand;

    // R1: candidate set of this channel
    for (genvar g = 0; g < LINES; g++) begin : g_cand
        assign cand[g] = pend_i[g] & ~mask_i[g] & (fast_i[g] == FAST_SEL);
    end

    // R2/R3: scan upward; "<=" lets a later line take an equal best value
    always_comb begin
        logic [PRIO_W-1:0] best;
        best  = '1;
        win_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (cand[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
                best  = prio_i[i*PRIO_W +: PRIO_W];
                win_o = CODE_W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_arb_channel.sv
module irq_arb_channel #(
    parameter int unsigned CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rearm_i,
    input  logic              any_i,
    input  logic [CODE_W-1:0] win_i,
    output logic              req_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic              arm;
        logic              req;
        logic [CODE_W-1:0] code;
    } ch_state_t;

    ch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rearm_i) begin
            state_d.req = 1'b0;
            state_d.arm = 1'b1;
        end else if (state_q.arm && any_i && en_i) begin
            state_d.req  = 1'b1;
            state_d.arm  = 1'b0;
            state_d.code = win_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.arm  <= 1'b1;
            state_q.req  <= 1'b0;
            state_q.code <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_o  = state_q.req;
    assign code_o = state_q.code;

    // R5: a rising request needs arm, a candidate and enable one cycle before
    p_rise_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.req) |-> $past(state_q.arm && any_i && en_i));

    // R6: re-arm drops the request on the next edge
    p_rearm_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (!state_q.req && state_q.arm));

    // R5: request held and armed are never both true
    p_req_not_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.req |-> !state_q.arm);

    // R8: a disarmed channel keeps its code
    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.arm |=> $stable(state_q.code));

    // R9: disabled channel cannot raise its request
    p_no_rise_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !state_q.req) |=> !state_q.req);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int unsigned N_BANKS = 3,
    parameter int unsigned PRIO_W  = 6,
    localparam int unsigned LINES  = N_BANKS * irq_arb_pkg::LINES_PER_BANK,
    localparam int unsigned CODE_W = irq_arb_pkg::code_width(LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    glb_en_i,
    input  logic [LINES-1:0]        pend_i,
    input  logic [LINES-1:0]        mask_i,
    input  logic [LINES-1:0]        fast_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    input  logic [1:0]              rearm_i,
    output logic [1:0]              req_o,
    output logic [CODE_W-1:0]       norm_code_o,
    output logic [CODE_W-1:0]       fast_code_o
);
    import irq_arb_pkg::*;

    logic [NUM_CHANNELS-1:0] any_w;
    logic [CODE_W-1:0]       win_w  [NUM_CHANNELS];
    logic [CODE_W-1:0]       code_w [NUM_CHANNELS];

    for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : g_ch
        irq_arb_search #(
            .LINES    (LINES),
            .PRIO_W   (PRIO_W),
            .CODE_W   (CODE_W),
            .FAST_SEL (ch == CH_FAST)
        ) i_search (
            .pend_i (pend_i),
            .mask_i (mask_i),
            .fast_i (fast_i),
            .prio_i (prio_i),
            .any_o  (any_w[ch]),
            .win_o  (win_w[ch])
        );

        irq_arb_channel #(
            .CODE_W (CODE_W)
        ) i_channel (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (glb_en_i),
            .rearm_i (rearm_i[ch]),
            .any_i   (any_w[ch]),
            .win_i   (win_w[ch]),
            .req_o   (req_o[ch]),
            .code_o  (code_w[ch])
        );
    end

    assign norm_code_o = code_w[CH_NORMAL];
    assign fast_code_o = code_w[CH_FAST];

    // R1: a winner reported by a search is a live, correctly routed line
    p_win_is_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_w[CH_FAST] |-> (pend_i[win_w[CH_FAST]] && !mask_i[win_w[CH_FAST]]
                            && fast_i[win_w[CH_FAST]]));

    // R10: re-arming only the normal channel leaves the fast request alone
    p_channels_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_i == 2'b01 && req_o[CH_FAST]) |=> req_o[CH_FAST]);
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
    localparam int NB = 3;
    localparam int PW = 6;
    localparam int LN = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glb_en;
    logic [LN-1:0] pend, mask, fast;
    logic [LN*PW-1:0] prio;
    logic [1:0]    rearm;
    logic [1:0]    req;
    logic [6:0]    ncode, fcode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_arbiter #(.N_BANKS(NB), .PRIO_W(PW)) i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en),
        .pend_i(pend), .mask_i(mask), .fast_i(fast), .prio_i(prio),
        .rearm_i(rearm), .req_o(req),
        .norm_code_o(ncode), .fast_code_o(fcode)
    );

    typedef struct packed {
        logic       v;
        logic [6:0] ln;
        logic [5:0] pr;
        logic       fs;
        logic       mk;
    } slot_t;

    typedef struct packed {
        slot_t      a, b, c;
        logic       nr;
        logic [6:0] nc;
        logic       fr;
        logic [6:0] fc;
    } vec_t;

    localparam slot_t NO = '{v:0, ln:0, pr:0, fs:0, mk:0};

    localparam vec_t VEC [10] = '{
        // 0: R4 single line
        '{a:'{1,5,10,0,0}, b:NO, c:NO, nr:1, nc:5, fr:0, fc:0},
        // 1: R2 lowest value wins across banks
        '{a:'{1,3,5,0,0}, b:'{1,40,2,0,0}, c:'{1,90,9,0,0}, nr:1, nc:40, fr:0, fc:0},
        // 2: R3 tie in bank 0
        '{a:'{1,0,7,0,0}, b:'{1,31,7,0,0}, c:NO, nr:1, nc:31, fr:0, fc:0},
        // 3: R3 tie across banks
        '{a:'{1,2,4,0,0}, b:'{1,70,4,0,0}, c:'{1,33,4,0,0}, nr:1, nc:70, fr:0, fc:0},
        // 4: R1 routing split
        '{a:'{1,10,1,1,0}, b:'{1,20,3,0,0}, c:NO, nr:1, nc:20, fr:1, fc:10},
        // 5: R1 masked best line skipped
        '{a:'{1,8,0,0,1}, b:'{1,9,30,0,0}, c:NO, nr:1, nc:9, fr:0, fc:0},
        // 6: R1 only masked line pending
        '{a:'{1,8,0,0,1}, b:NO, c:NO, nr:0, nc:0, fr:0, fc:0},
        // 7: R3 fast tie, normal separate
        '{a:'{1,64,0,1,0}, b:'{1,95,0,1,0}, c:'{1,1,0,0,0}, nr:1, nc:1, fr:1, fc:95},
        // 8: R2 extreme values
        '{a:'{1,95,63,0,0}, b:'{1,0,0,0,0}, c:NO, nr:1, nc:0, fr:0, fc:0},
        // 9: R1 masked fast line skipped
        '{a:'{1,3,0,1,1}, b:'{1,4,9,1,0}, c:NO, nr:0, nc:0, fr:1, fc:4}
    };

    function automatic string vec_tag(input int k);
        case (k)
            0:          return "R4";
            1, 8:       return "R2";
            2, 3, 7:    return "R3";
            default:    return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_lines();
        pend = '0; mask = '0; fast = '0; prio = '1;
    endtask

    task automatic put_slot(input slot_t s);
        if (s.v) begin
            pend[s.ln]          = 1'b1;
            mask[s.ln]          = s.mk;
            fast[s.ln]          = s.fs;
            prio[s.ln*PW +: PW] = s.pr;
        end
    endtask

    task automatic put_line(input int ln, input int pr, input bit fs);
        pend[ln]          = 1'b1;
        mask[ln]          = 1'b0;
        fast[ln]          = fs;
        prio[ln*PW +: PW] = PW'(pr);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        glb_en = 1'b1;
        rearm  = 2'b00;
        clear_lines();
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 normal req", int'(req[0]), 0);
        chk("R7 fast req",   int'(req[1]), 0);
        chk("R7 normal code", int'(ncode), 0);
        chk("R7 fast code",   int'(fcode), 0);
        rst_n = 1'b1;
        tick();
        chk("R7 idle after reset", int'(req), 0);

        // table walk: re-arm both, load pattern, evaluate
        for (int k = 0; k < 10; k++) begin
            clear_lines();
            put_slot(VEC[k].a);
            put_slot(VEC[k].b);
            put_slot(VEC[k].c);
            rearm = 2'b11;
            tick();
            rearm = 2'b00;
            tick();
            chk({vec_tag(k), " normal req"}, int'(req[0]), int'(VEC[k].nr));
            chk({vec_tag(k), " fast req"},   int'(req[1]), int'(VEC[k].fr));
            if (VEC[k].nr) chk({vec_tag(k), " normal code"}, int'(ncode), int'(VEC[k].nc));
            if (VEC[k].fr) chk({vec_tag(k), " fast code"},   int'(fcode), int'(VEC[k].fc));
        end
        // after vector 9: normal armed without candidate, fast holds code 4

        // R5: raised request stays and keeps its code while new lines arrive
        rearm = 2'b11;
        tick();
        rearm = 2'b00;
        clear_lines();
        put_line(0, 5, 0);
        put_line(60, 3, 1);
        tick();
        chk("R5 normal raised", int'(req[0]), 1);
        chk("R5 normal code",   int'(ncode), 0);
        chk("R5 fast code",     int'(fcode), 60);
        put_line(50, 0, 0);
        tick();
        tick();
        chk("R5 still high", int'(req[0]), 1);
        chk("R5 code unchanged", int'(ncode), 0);

        // R6 / R10: re-arm normal only
        rearm = 2'b01;
        tick();
        chk("R6 dropped", int'(req[0]), 0);
        chk("R10 fast req kept", int'(req[1]), 1);
        chk("R10 fast code kept", int'(fcode), 60);
        rearm = 2'b00;
        tick();
        chk("R6 re-evaluated", int'(req[0]), 1);
        chk("R6 new code", int'(ncode), 50);

        // R8: re-arm with no normal candidate keeps the code
        pend[0]  = 1'b0;
        pend[50] = 1'b0;
        rearm = 2'b01;
        tick();
        rearm = 2'b00;
        tick();
        tick();
        chk("R8 no raise", int'(req[0]), 0);
        chk("R8 code retained", int'(ncode), 50);

        // R9: a change is evaluated on the next edge
        put_line(7, 2, 0);
        tick();
        chk("R9 next-edge raise", int'(req[0]), 1);
        chk("R9 next-edge code", int'(ncode), 7);

        // R9: enable gating
        glb_en = 1'b0;
        rearm  = 2'b11;
        clear_lines();
        put_line(12, 1, 0);
        put_line(60, 3, 1);
        tick();
        rearm = 2'b00;
        tick();
        tick();
        chk("R9 gated normal", int'(req[0]), 0);
        chk("R9 gated fast",   int'(req[1]), 0);
        glb_en = 1'b1;
        tick();
        chk("R9 enable normal", int'(req[0]), 1);
        chk("R9 enable code",   int'(ncode), 12);
        chk("R9 enable fast",   int'(req[1]), 1);

        // R6: re-arm held high keeps the request low
        rearm = 2'b01;
        tick();
        tick();
        chk("R6 held low", int'(req[0]), 0);
        rearm = 2'b00;
        tick();
        chk("R6 release raise", int'(req[0]), 1);

        done = 1'b1;
        finish_run();
    end
endmodule